// File: doc/BRIEF.md
# Strict-Priority Outbound Packet Queue with Acknowledge and Retry

This block is the transmit-side packet buffer of one port of a serial packet link. A central switch hands it packet descriptors (identifier, byte count, priority) one per cycle. Each descriptor lands in a FIFO chosen by its priority. When the line can take data, the block picks the oldest packet of the highest non-empty priority and sends it as a run of beats. The run opens with a start marker and closes with an end marker.

A packet that has started is moved into a table of packets that are waiting for the link partner's verdict. The partner returns one response per packet, tagged with that packet's identifier. An accept frees the entry. A reject sends the packet back to the tail of its priority FIFO, where it queues like a fresh arrival. While any priority FIFO is full, the block stalls the whole switch. Between the start and end beats it signals that the link may slip a control symbol into the stream.

Top module: `prio_emit_queue`

## Requirements
- R1: After reset, `sw_stall`, `tx_beat`, `cs_window` and `ack_unknown` are all low.
- R2: Priority 3 is the highest and priority 0 the lowest. A new packet always comes from the highest non-empty priority FIFO, and packets of one priority leave in arrival order.
- R3: A packet of `S` bytes is sent as ceil(S/32) beats, with a minimum of one. `tx_sop` marks the first beat and `tx_eop` the last, so a one-beat packet carries both. A beat is consumed in each cycle in which `tx_beat` and `line_ready` are both high.
- R4: `cs_window` is high from the cycle after a non-final first beat is consumed until the cycle after the final beat is consumed. While it is high and `line_ready` is low, the beat and its descriptor are held unchanged.
- R5: `sw_stall` is high whenever any priority FIFO holds 4 packets. A descriptor offered with `sw_valid` while `sw_stall` is high is not taken. Once high, `sw_stall` falls only after a packet has left a FIFO.
- R6: The waiting table holds 8 packets. A packet starts only when the table has a free entry, and it moves from its FIFO into the table when its first beat is consumed.
- R7: A response with `ack_retry`=0 removes only the waiting entry whose identifier equals `ack_id`. All other entries stay and can still be accepted or rejected later.
- R8: A response with `ack_retry`=1 for a waiting packet returns that packet to the tail of its own priority FIFO, behind packets already queued there, and it is sent again.
- R9: If a rejected packet's FIFO is full, the packet stays in the waiting table and re-enters that FIFO as soon as there is room.
- R10: A response whose identifier matches no waiting entry changes nothing, and `ack_unknown` goes high for one cycle in the cycle after it.
- R11: A switch descriptor and a partner response presented in the same cycle are both taken and both acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sw_valid | input | 1 | Switch offers a descriptor |
| sw_id | input | 8 | Packet identifier |
| sw_size | input | 9 | Packet length in bytes (1 to 280) |
| sw_prio | input | 2 | Packet priority, 3 highest |
| sw_stall | output | 1 | Switch must hold; offers are not taken |
| line_ready | input | 1 | Line consumes the current beat |
| tx_beat | output | 1 | A beat is presented |
| tx_sop | output | 1 | Presented beat is the first of a packet |
| tx_eop | output | 1 | Presented beat is the last of a packet |
| tx_id | output | 8 | Identifier of the packet on the line |
| tx_size | output | 9 | Length of the packet on the line |
| tx_prio | output | 2 | Priority of the packet on the line |
| cs_window | output | 1 | A packet is open; a control symbol may be inserted |
| ack_valid | input | 1 | Partner response present |
| ack_retry | input | 1 | 1 = reject (resend), 0 = accept |
| ack_id | input | 8 | Identifier the response refers to |
| ack_unknown | output | 1 | Previous response matched no waiting packet |

## Verification
The bound checker watches every cycle for the beat framing rules, the opening, closing and holding of the control-symbol window, the rule that no lower priority starts while a higher one waits, and the rule that no packet starts while the waiting table is full. It also checks that the stall releases only after a packet has left a FIFO and that the unknown flag follows a response. Ordering effects that span many cycles can only be shown by the bench's scenarios: a rejected packet landing behind later arrivals, a rejected packet held back by a full FIFO, a descriptor ignored during a stall, and an accept that clears exactly one entry.

// File: rtl/peq_pkg.sv
package peq_pkg;
    localparam int NUM_PRIO = 4;
    localparam int PRIO_W   = $clog2(NUM_PRIO);
    localparam int ID_W     = 8;
    localparam int SIZE_W   = 9;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [SIZE_W-1:0] size;
        logic [PRIO_W-1:0] prio;
    } desc_t;
endpackage

// File: rtl/peq_fifo.sv
// One priority level's descriptor FIFO; accepts a new and a returned descriptor in one cycle.
module peq_fifo
    import peq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_new,
    input  desc_t         new_desc,
    input  logic          push_rq,
    input  desc_t         rq_desc,
    input  logic          pop,
    output desc_t         head,
    output logic [CW-1:0] count
);
    typedef struct {
        desc_t          mem [DEPTH];
        logic [PW-1:0]  wr;
        logic [PW-1:0]  rd;
        logic [CW-1:0]  cnt;
    } fifo_st_t;

    fifo_st_t      st_d, st_q;
    logic [PW-1:0] wp;

    always_comb begin
        st_d = st_q;
        wp   = st_q.wr;
        if (pop) st_d.rd = st_q.rd + 1'b1;
        // fresh arrival goes ahead of a returned packet in the same cycle
        if (push_new) begin
            st_d.mem[wp] = new_desc;
            wp = wp + 1'b1;
        end
        if (push_rq) begin
            st_d.mem[wp] = rq_desc;
            wp = wp + 1'b1;
        end
        st_d.wr  = wp;
        st_d.cnt = st_q.cnt + CW'(push_new) + CW'(push_rq) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wr  <= '0;
            st_q.rd  <= '0;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head  = st_q.mem[st_q.rd];
    assign count = st_q.cnt;
endmodule

// File: rtl/peq_pend.sv
// Table of started packets waiting for an accept or reject from the link partner.
module peq_pend
    import peq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ins_valid,
    input  desc_t               ins_desc,
    input  logic                resp_valid,
    input  logic                resp_retry,
    input  logic [ID_W-1:0]     resp_id,
    input  logic [NUM_PRIO-1:0] room,
    output logic                full,
    output logic                rq_valid,
    output desc_t               rq_desc,
    output logic                unknown
);
    typedef struct {
        desc_t            ent [DEPTH];
        logic [DEPTH-1:0] used;
        logic [DEPTH-1:0] back;   // rejected, waiting to re-enter its FIFO
        logic             unk;
    } pend_st_t;

    pend_st_t      st_d, st_q;
    logic [IW-1:0] free_idx, hit_idx, rq_idx;
    logic          free_ok, hit_ok, rq_ok;

    always_comb begin
        free_idx = '0; free_ok = 1'b0;
        hit_idx  = '0; hit_ok  = 1'b0;
        rq_idx   = '0; rq_ok   = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!st_q.used[i]) begin
                free_idx = IW'(i);
                free_ok  = 1'b1;
            end
            if (st_q.used[i] && !st_q.back[i] && st_q.ent[i].id == resp_id) begin
                hit_idx = IW'(i);
                hit_ok  = 1'b1;
            end
            if (st_q.used[i] && st_q.back[i] && room[st_q.ent[i].prio]) begin
                rq_idx = IW'(i);
                rq_ok  = 1'b1;
            end
        end

        st_d     = st_q;
        st_d.unk = 1'b0;
        if (ins_valid && free_ok) begin
            st_d.used[free_idx] = 1'b1;
            st_d.back[free_idx] = 1'b0;
            st_d.ent[free_idx]  = ins_desc;
        end
        if (resp_valid) begin
            if (hit_ok) begin
                if (resp_retry) st_d.back[hit_idx] = 1'b1;
                else            st_d.used[hit_idx] = 1'b0;
            end else begin
                st_d.unk = 1'b1;
            end
        end
        if (rq_ok) begin
            st_d.used[rq_idx] = 1'b0;
            st_d.back[rq_idx] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.used <= '0;
            st_q.back <= '0;
            st_q.unk  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full     = !free_ok;
    assign rq_valid = rq_ok;
    assign rq_desc  = st_q.ent[rq_idx];
    assign unknown  = st_q.unk;
endmodule

// File: rtl/peq_framer.sv
// Turns a chosen descriptor into a run of beats with start and end markers.
module peq_framer
    import peq_pkg::*;
#(
    parameter int BEAT_BYTES = 32
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cand_valid,
    input  desc_t cand,
    input  logic  line_ready,
    output logic  beat,
    output logic  sop,
    output logic  eop,
    output logic  open,
    output logic  start,
    output desc_t cur
);
    localparam int LW  = SIZE_W;
    localparam int SW1 = SIZE_W + 1;

    function automatic logic [LW-1:0] beats_of(input logic [SIZE_W-1:0] sz);
        logic [SW1-1:0] t;
        t = ({1'b0, sz} + SW1'(BEAT_BYTES - 1)) / SW1'(BEAT_BYTES);
        if (t == '0) t = SW1'(1);
        return LW'(t);
    endfunction

    typedef struct packed {
        logic          busy;
        logic [LW-1:0] left;
        desc_t         cur;
    } frm_st_t;

    frm_st_t       st_d, st_q;
    logic [LW-1:0] nb;

    always_comb begin
        st_d  = st_q;
        nb    = beats_of(cand.size);
        beat  = 1'b0;
        sop   = 1'b0;
        eop   = 1'b0;
        start = 1'b0;
        cur   = st_q.cur;
        if (!st_q.busy) begin
            beat  = cand_valid;
            sop   = cand_valid;
            eop   = cand_valid && (nb == LW'(1));
            cur   = cand;
            start = cand_valid && line_ready;
            if (start && nb != LW'(1)) begin
                st_d.busy = 1'b1;
                st_d.left = nb - LW'(1);
                st_d.cur  = cand;
            end
        end else begin
            beat = 1'b1;
            eop  = (st_q.left == LW'(1));
            if (line_ready) begin
                st_d.left = st_q.left - LW'(1);
                if (eop) st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign open = st_q.busy;
endmodule

// File: rtl/prio_emit_queue.sv
module prio_emit_queue
    import peq_pkg::*;
#(
    parameter int Q_DEPTH    = 4,
    parameter int PEND_DEPTH = 8,
    parameter int BEAT_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_valid,
    input  logic [ID_W-1:0]   sw_id,
    input  logic [SIZE_W-1:0] sw_size,
    input  logic [PRIO_W-1:0] sw_prio,
    output logic              sw_stall,
    input  logic              line_ready,
    output logic              tx_beat,
    output logic              tx_sop,
    output logic              tx_eop,
    output logic [ID_W-1:0]   tx_id,
    output logic [SIZE_W-1:0] tx_size,
    output logic [PRIO_W-1:0] tx_prio,
    output logic              cs_window,
    input  logic              ack_valid,
    input  logic              ack_retry,
    input  logic [ID_W-1:0]   ack_id,
    output logic              ack_unknown
);
    localparam int CW = $clog2(Q_DEPTH + 1);

    desc_t               q_head [NUM_PRIO];
    logic [CW-1:0]       q_cnt  [NUM_PRIO];
    logic [NUM_PRIO-1:0] q_nonempty, q_full, q_room, push_new, push_rq, pop;
    desc_t               sw_desc, sel_desc, rq_desc, cur;
    logic [PRIO_W-1:0]   sel;
    logic                enq_fire, pend_full, rq_valid, cand_valid, start;

    assign sw_desc  = '{id: sw_id, size: sw_size, prio: sw_prio};
    assign sw_stall = |q_full;
    assign enq_fire = sw_valid && !sw_stall;

    for (genvar p = 0; p < NUM_PRIO; p++) begin : g_lvl
        assign q_nonempty[p] = (q_cnt[p] != '0);
        assign q_full[p]     = (q_cnt[p] == CW'(Q_DEPTH));
        assign push_new[p]   = enq_fire && (sw_prio == PRIO_W'(p));
        assign push_rq[p]    = rq_valid && (rq_desc.prio == PRIO_W'(p));
        assign pop[p]        = start && (sel == PRIO_W'(p));
        // a returned packet needs a slot beyond any arrival in the same cycle
        assign q_room[p]     = ({1'b0, q_cnt[p]} + (CW+1)'(push_new[p])) < (CW+1)'(Q_DEPTH);

        peq_fifo #(.DEPTH(Q_DEPTH)) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .push_new (push_new[p]),
            .new_desc (sw_desc),
            .push_rq  (push_rq[p]),
            .rq_desc  (rq_desc),
            .pop      (pop[p]),
            .head     (q_head[p]),
            .count    (q_cnt[p])
        );
    end

    // strict priority: the last non-empty level scanned upward wins
    always_comb begin
        sel = '0;
        for (int p = 0; p < NUM_PRIO; p++) begin
            if (q_nonempty[p]) sel = PRIO_W'(p);
        end
        sel_desc = q_head[sel];
    end

    assign cand_valid = (|q_nonempty) && !pend_full;

    peq_framer #(.BEAT_BYTES(BEAT_BYTES)) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cand_valid (cand_valid),
        .cand       (sel_desc),
        .line_ready (line_ready),
        .beat       (tx_beat),
        .sop        (tx_sop),
        .eop        (tx_eop),
        .open       (cs_window),
        .start      (start),
        .cur        (cur)
    );

    peq_pend #(.DEPTH(PEND_DEPTH)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .ins_valid  (start),
        .ins_desc   (sel_desc),
        .resp_valid (ack_valid),
        .resp_retry (ack_retry),
        .resp_id    (ack_id),
        .room       (q_room),
        .full       (pend_full),
        .rq_valid   (rq_valid),
        .rq_desc    (rq_desc),
        .unknown    (ack_unknown)
    );

    assign tx_id   = cur.id;
    assign tx_size = cur.size;
    assign tx_prio = cur.prio;
endmodule

// File: rtl/prio_emit_queue_chk.sv
module prio_emit_queue_chk
    import peq_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                line_ready,
    input logic                tx_beat,
    input logic                tx_sop,
    input logic                tx_eop,
    input logic [ID_W-1:0]     tx_id,
    input logic [PRIO_W-1:0]   tx_prio,
    input logic                cs_window,
    input logic                sw_stall,
    input logic                ack_valid,
    input logic                ack_unknown,
    input logic [NUM_PRIO-1:0] q_nonempty,
    input logic                pend_full
);
    // R3
    sop_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sop |-> tx_beat);
    // R3
    eop_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_eop |-> tx_beat);
    // R4
    window_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sop && line_ready && !tx_eop) |=> cs_window);
    // R4
    window_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_eop && line_ready) |=> !cs_window);
    // R4
    window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_window && !line_ready) |=> (tx_beat && $stable(tx_id) && $stable(tx_prio)));
    // R2
    strict_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sop |-> (((q_nonempty >> tx_prio) >> 1) == '0));
    // R5
    stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_stall) |-> $past(tx_sop && line_ready));
    // R6
    pend_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_full |-> !tx_sop);
    // R10
    unknown_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_unknown |-> $past(ack_valid));
endmodule

bind prio_emit_queue prio_emit_queue_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_ready  (line_ready),
    .tx_beat     (tx_beat),
    .tx_sop      (tx_sop),
    .tx_eop      (tx_eop),
    .tx_id       (tx_id),
    .tx_prio     (tx_prio),
    .cs_window   (cs_window),
    .sw_stall    (sw_stall),
    .ack_valid   (ack_valid),
    .ack_unknown (ack_unknown),
    .q_nonempty  (q_nonempty),
    .pend_full   (pend_full)
);

// File: tb/prio_emit_queue_bench.sv
`timescale 1ns/1ps
module prio_emit_queue_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       sw_valid, line_ready, ack_valid, ack_retry;
    logic [7:0] sw_id, ack_id;
    logic [8:0] sw_size;
    logic [1:0] sw_prio;
    logic       sw_stall, tx_beat, tx_sop, tx_eop, cs_window, ack_unknown;
    logic [7:0] tx_id;
    logic [8:0] tx_size;
    logic [1:0] tx_prio;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    prio_emit_queue u_prio_emit_queue (
        .clk(clk), .rst_n(rst_n),
        .sw_valid(sw_valid), .sw_id(sw_id), .sw_size(sw_size), .sw_prio(sw_prio),
        .sw_stall(sw_stall),
        .line_ready(line_ready), .tx_beat(tx_beat), .tx_sop(tx_sop), .tx_eop(tx_eop),
        .tx_id(tx_id), .tx_size(tx_size), .tx_prio(tx_prio), .cs_window(cs_window),
        .ack_valid(ack_valid), .ack_retry(ack_retry), .ack_id(ack_id),
        .ack_unknown(ack_unknown)
    );

    typedef struct packed {
        logic [7:0] id;
        logic [8:0] size;
        logic [1:0] prio;
        int         beats;
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{8'd10, 9'd5,   2'd1, 1},
        '{8'd11, 9'd40,  2'd0, 2},
        '{8'd12, 9'd280, 2'd3, 9},
        '{8'd13, 9'd64,  2'd1, 2},
        '{8'd14, 9'd33,  2'd2, 2},
        '{8'd15, 9'd1,   2'd3, 1},
        '{8'd16, 9'd256, 2'd0, 8}
    };
    localparam int ORDER [7] = '{2, 5, 4, 0, 3, 1, 6};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic enq(input logic [7:0] id, input logic [8:0] sz, input logic [1:0] pr);
        @(negedge clk);
        sw_valid = 1'b1; sw_id = id; sw_size = sz; sw_prio = pr;
        @(negedge clk);
        sw_valid = 1'b0;
    endtask

    task automatic resp(input bit retry, input logic [7:0] id, input bit exp_unk, input string req);
        @(negedge clk);
        ack_valid = 1'b1; ack_retry = retry; ack_id = id;
        @(negedge clk);
        ack_valid = 1'b0; ack_retry = 1'b0;
        check(ack_unknown == exp_unk, req, ack_unknown, exp_unk);
    endtask

    task automatic enq_and_resp(input logic [7:0] id, input logic [1:0] pr,
                                input bit retry, input logic [7:0] rid);
        @(negedge clk);
        sw_valid = 1'b1; sw_id = id; sw_size = 9'd1; sw_prio = pr;
        ack_valid = 1'b1; ack_retry = retry; ack_id = rid;
        @(negedge clk);
        sw_valid = 1'b0; ack_valid = 1'b0; ack_retry = 1'b0;
        check(ack_unknown == 1'b0, "R11", ack_unknown, 0);
    endtask

    // sends exactly one packet; returns its id and beat count
    task automatic send_next(output logic [7:0] id, output int beats, output bit ok);
        int t = 0;
        beats = 0; id = '0; ok = 1'b0;
        @(negedge clk);
        line_ready = 1'b1;
        while (!(tx_beat && tx_sop)) begin
            if (t == 60) break;
            @(negedge clk);
            t++;
        end
        if (!(tx_beat && tx_sop)) begin
            line_ready = 1'b0;
            return;
        end
        id = tx_id;
        while (1) begin
            beats++;
            if (tx_eop || beats > 400) break;
            @(negedge clk);
        end
        @(posedge clk);
        #1 line_ready = 1'b0;
        ok = 1'b1;
    endtask

    task automatic expect_send(input logic [7:0] exp_id, input string req);
        logic [7:0] got; int nb; bit ok;
        send_next(got, nb, ok);
        check(ok && got == exp_id, req, ok ? int'(got) : -1, exp_id);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] got; int nb; bit ok;
        rst_n = 1'b0; sw_valid = 1'b0; line_ready = 1'b0;
        ack_valid = 1'b0; ack_retry = 1'b0; ack_id = '0;
        sw_id = '0; sw_size = '0; sw_prio = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(sw_stall == 1'b0,    "R1", sw_stall, 0);
        check(tx_beat == 1'b0,     "R1", tx_beat, 0);
        check(cs_window == 1'b0,   "R1", cs_window, 0);
        check(ack_unknown == 1'b0, "R1", ack_unknown, 0);

        // R2 / R3: table of mixed priorities and sizes, checked in send order
        foreach (VEC[i]) enq(VEC[i].id, VEC[i].size, VEC[i].prio);
        for (int k = 0; k < 7; k++) begin
            send_next(got, nb, ok);
            check(ok && got == VEC[ORDER[k]].id, "R2", got, VEC[ORDER[k]].id);
            check(nb == VEC[ORDER[k]].beats,     "R3", nb, VEC[ORDER[k]].beats);
        end
        foreach (VEC[i]) resp(1'b0, VEC[i].id, 1'b0, "R7");

        // R5: fill priority 2, stall, ignored offer, release after a departure
        for (int i = 0; i < 4; i++) enq(8'(30 + i), 9'd1, 2'd2);
        check(sw_stall == 1'b1, "R5", sw_stall, 1);
        enq(8'd99, 9'd1, 2'd3);
        repeat (3) @(negedge clk);
        check(sw_stall == 1'b1, "R5", sw_stall, 1);
        expect_send(8'd30, "R5");
        @(negedge clk);
        check(sw_stall == 1'b0, "R5", sw_stall, 0);
        for (int i = 1; i < 4; i++) expect_send(8'(30 + i), "R5");
        @(negedge clk);
        check(tx_beat == 1'b0, "R5", tx_beat, 0);
        for (int i = 0; i < 4; i++) resp(1'b0, 8'(30 + i), 1'b0, "R7");

        // R4: three-beat packet with a line pause inside it
        enq(8'd40, 9'd70, 2'd0);
        check(tx_sop && !cs_window, "R4", cs_window, 0);
        line_ready = 1'b1;
        @(negedge clk);
        line_ready = 1'b0;
        check(cs_window && tx_beat && !tx_sop, "R4", cs_window, 1);
        @(negedge clk);
        check(cs_window && tx_id == 8'd40, "R4", tx_id, 40);
        line_ready = 1'b1;
        @(negedge clk);
        check(tx_eop && cs_window, "R4", tx_eop, 1);
        @(negedge clk);
        line_ready = 1'b0;
        check(cs_window == 1'b0, "R4", cs_window, 0);
        resp(1'b0, 8'd40, 1'b0, "R7");

        // R8: reject returns the packet behind later arrivals of its level
        enq(8'd50, 9'd1, 2'd1);
        enq(8'd51, 9'd1, 2'd1);
        enq(8'd52, 9'd1, 2'd1);
        expect_send(8'd50, "R8");
        enq_and_resp(8'd53, 2'd1, 1'b1, 8'd50);
        expect_send(8'd51, "R8");
        expect_send(8'd52, "R8");
        expect_send(8'd53, "R8");
        expect_send(8'd50, "R8");
        for (int i = 50; i < 54; i++) resp(1'b0, 8'(i), 1'b0, "R7");

        // R7 / R10: accept one of two, reject the other, then unknown ids
        enq(8'd60, 9'd1, 2'd0);
        enq(8'd61, 9'd1, 2'd0);
        expect_send(8'd60, "R7");
        expect_send(8'd61, "R7");
        resp(1'b0, 8'd61, 1'b0, "R7");
        resp(1'b1, 8'd60, 1'b0, "R7");
        expect_send(8'd60, "R7");
        resp(1'b0, 8'd60, 1'b0, "R7");
        resp(1'b0, 8'd61, 1'b1, "R10");
        resp(1'b1, 8'd99, 1'b1, "R10");
        @(negedge clk);
        check(ack_unknown == 1'b0, "R10", ack_unknown, 0);
        repeat (3) @(negedge clk);
        check(tx_beat == 1'b0, "R10", tx_beat, 0);

        // R9: rejected packet held while its level is full
        enq(8'd70, 9'd1, 2'd3);
        expect_send(8'd70, "R9");
        for (int i = 71; i < 75; i++) enq(8'(i), 9'd1, 2'd3);
        resp(1'b1, 8'd70, 1'b0, "R9");
        repeat (5) @(negedge clk);
        check(sw_stall == 1'b1, "R9", sw_stall, 1);
        for (int i = 71; i < 75; i++) expect_send(8'(i), "R9");
        expect_send(8'd70, "R9");
        for (int i = 70; i < 75; i++) resp(1'b0, 8'(i), 1'b0, "R7");

        // R11: arrival and accept in the same cycle
        enq(8'd80, 9'd1, 2'd2);
        expect_send(8'd80, "R11");
        enq_and_resp(8'd81, 2'd2, 1'b0, 8'd80);
        expect_send(8'd81, "R11");
        resp(1'b0, 8'd80, 1'b1, "R11");
        resp(1'b0, 8'd81, 1'b0, "R11");

        // R6: waiting table full blocks the next start
        for (int i = 90; i < 98; i++) begin
            enq(8'(i), 9'd1, 2'd0);
            expect_send(8'(i), "R6");
        end
        enq(8'd98, 9'd1, 2'd0);
        check(tx_beat == 1'b0, "R6", tx_beat, 0);
        @(negedge clk);
        check(tx_beat == 1'b0, "R6", tx_beat, 0);
        resp(1'b0, 8'd90, 1'b0, "R6");
        check(tx_beat == 1'b1, "R6", tx_beat, 1);
        expect_send(8'd98, "R6");
        for (int i = 91; i < 99; i++) resp(1'b0, 8'(i), 1'b0, "R7");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule